// File: doc/BRIEF.md
# Dual-Bank Coefficient Write Interleaver

This block sits between a lifting-based wavelet filter and a pair of dual-port memory banks. It takes a low-pass coefficient stream and a high-pass coefficient stream. It sends each stream to one bank and produces the write enable, the write address and the write data for both banks. Bank ownership swaps every time a fixed-size group of low-pass coefficients has been written. The high-pass stream always takes the bank that the low-pass stream is not using.

Inside the block, the high-pass stream passes through a fixed skew of `SKEW` cycles (32 by default) before it is written. Conflicts between the two streams are therefore settled by the schedule, and no arbiter is needed. Each bank is split into two regions by the top address bit: one region holds low-pass coefficients and the other holds high-pass coefficients. A separate read-side address generator walks through a line in step with the same bank rotation. Its crossbar returns the word from the currently selected bank. Reads and writes are treated as taking effect in the same cycle. Any balancing for memory or filter latency is done outside the block.

Top module: `dual_bank_interleaver`

## Requirements
- R1: While reset is held and just after it is released, neither bank write enable is asserted, the low-pass stream targets bank 0, every coefficient index is 0, and `rd_data` is taken from bank 0.
- R2: In a cycle with `lo_vld` high, the bank currently owned by the low-pass stream has its write enable asserted in that same cycle. Its write address is `{1'b0, lo_index}` and its write data equals `lo_data`.
- R3: The low-pass bank select inverts after every `SKEW` low-pass writes (32 by default). Cycles without `lo_vld` do not advance it.
- R4: The low-pass index increases by one on each low-pass write. After `LINE_LEN-1` (63 by default) it returns to 0.
- R5: A high-pass coefficient presented in cycle c is written in cycle c+`SKEW`. It goes to the bank opposite the low-pass bank of that cycle, at address `{1'b1, hi_index}`, where hi_index is a separate counter that wraps at `LINE_LEN`. Nothing is written for it before then.
- R6: When a low-pass write and a skewed high-pass write fall in the same cycle, both are carried out and they go to different banks.
- R7: Both bank read addresses equal `{rd_hi, rd_index}`. rd_index increases by one on each `rd_en` and wraps from `LINE_LEN-1` to 0.
- R8: `rd_data` comes from bank 0 or bank 1 in the same cycle, with no added latency. The read bank select starts at bank 0 and inverts after every `SKEW` accepted reads.
- R9: In a cycle with no low-pass write and no skewed high-pass write, neither write enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_vld | input | 1 | Low-pass coefficient valid |
| lo_data | input | DW | Low-pass coefficient |
| hi_vld | input | 1 | High-pass coefficient valid (before the skew) |
| hi_data | input | DW | High-pass coefficient |
| rd_en | input | 1 | Advance the read address generator |
| rd_hi | input | 1 | Read region select: 0 low-pass, 1 high-pass |
| b0_we | output | 1 | Bank 0 write enable |
| b0_waddr | output | IW+1 | Bank 0 write address |
| b0_wdata | output | DW | Bank 0 write data |
| b1_we | output | 1 | Bank 1 write enable |
| b1_waddr | output | IW+1 | Bank 1 write address |
| b1_wdata | output | DW | Bank 1 write data |
| b0_raddr | output | IW+1 | Bank 0 read address |
| b1_raddr | output | IW+1 | Bank 1 read address |
| b0_rdata | input | DW | Bank 0 read data |
| b1_rdata | input | DW | Bank 1 read data |
| rd_data | output | DW | Read data from the selected bank |

## Verification
Each internal register has a direct effect at the ports:
- A wrong low-pass bank select appears in the very next low-pass write as the wrong enable asserting.
- A miscounted group boundary shows up at write 33, where the bank swap must happen.
- A wrong index wrap appears as a nonzero address on write 65.
- A skew line of the wrong depth sends the high-pass coefficient to a port one or more cycles early or late. Checking every cycle of the 32-cycle window detects this.
- Read-side select errors appear on `rd_data` at read 33.

// File: rtl/dual_bank_interleaver.sv
module dual_bank_interleaver #(
  parameter int DW       = 16,
  parameter int LINE_LEN = 64,
  parameter int SKEW     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lo_vld,
  input  logic [DW-1:0]               lo_data,
  input  logic                        hi_vld,
  input  logic [DW-1:0]               hi_data,
  input  logic                        rd_en,
  input  logic                        rd_hi,
  output logic                        b0_we,
  output logic [$clog2(LINE_LEN):0]   b0_waddr,
  output logic [DW-1:0]               b0_wdata,
  output logic                        b1_we,
  output logic [$clog2(LINE_LEN):0]   b1_waddr,
  output logic [DW-1:0]               b1_wdata,
  output logic [$clog2(LINE_LEN):0]   b0_raddr,
  output logic [$clog2(LINE_LEN):0]   b1_raddr,
  input  logic [DW-1:0]               b0_rdata,
  input  logic [DW-1:0]               b1_rdata,
  output logic [DW-1:0]               rd_data
);
  localparam int IW = $clog2(LINE_LEN);
  localparam int AW = IW + 1;
  localparam int GW = $clog2(SKEW);
  localparam logic [IW-1:0] IDX_LAST = IW'(LINE_LEN - 1);
  localparam logic [GW-1:0] GRP_LAST = GW'(SKEW - 1);

  logic [IW-1:0] lo_idx, hi_idx, rd_idx;
  logic [GW-1:0] lo_grp, rd_grp;
  logic          lo_bank, rd_bank;
  logic [DW:0]   skew_q [SKEW];
  logic          hd_v;
  logic [DW-1:0] hd_d;

  // high-pass skew line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SKEW; i++) skew_q[i] <= '0;
    end else begin
      skew_q[0] <= {hi_vld, hi_data};
      for (int i = 1; i < SKEW; i++) skew_q[i] <= skew_q[i-1];
    end
  end

  assign hd_v = skew_q[SKEW-1][DW];
  assign hd_d = skew_q[SKEW-1][DW-1:0];

  // low-pass index and bank rotation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_idx  <= '0;
      lo_grp  <= '0;
      lo_bank <= 1'b0;
    end else if (lo_vld) begin
      lo_idx <= (lo_idx == IDX_LAST) ? '0 : lo_idx + 1'b1;
      if (lo_grp == GRP_LAST) begin
        lo_grp  <= '0;
        lo_bank <= ~lo_bank;
      end else begin
        lo_grp <= lo_grp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_idx <= '0;
    else if (hd_v) hi_idx <= (hi_idx == IDX_LAST) ? '0 : hi_idx + 1'b1;
  end

  // write crossbar: high-pass always takes the bank low-pass does not own
  logic lo_to0, lo_to1, hi_to0, hi_to1;
  assign lo_to0 = lo_vld & ~lo_bank;
  assign lo_to1 = lo_vld &  lo_bank;
  assign hi_to0 = hd_v   &  lo_bank;
  assign hi_to1 = hd_v   & ~lo_bank;

  assign b0_we    = lo_to0 | hi_to0;
  assign b0_waddr = lo_to0 ? {1'b0, lo_idx} : {1'b1, hi_idx};
  assign b0_wdata = lo_to0 ? lo_data : hd_d;
  assign b1_we    = lo_to1 | hi_to1;
  assign b1_waddr = lo_to1 ? {1'b0, lo_idx} : {1'b1, hi_idx};
  assign b1_wdata = lo_to1 ? lo_data : hd_d;

  // read address generator and read crossbar
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      rd_grp  <= '0;
      rd_bank <= 1'b0;
    end else if (rd_en) begin
      rd_idx <= (rd_idx == IDX_LAST) ? '0 : rd_idx + 1'b1;
      if (rd_grp == GRP_LAST) begin
        rd_grp  <= '0;
        rd_bank <= ~rd_bank;
      end else begin
        rd_grp <= rd_grp + 1'b1;
      end
    end
  end

  assign b0_raddr = {rd_hi, rd_idx};
  assign b1_raddr = {rd_hi, rd_idx};
  assign rd_data  = rd_bank ? b1_rdata : b0_rdata;

  a_r6_no_bank_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (b0_we && b1_we) |-> (b0_waddr[AW-1] != b1_waddr[AW-1]));

  a_r4_lo_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_vld && lo_idx == IDX_LAST) |=> (lo_idx == '0));

  a_r3_bank_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_bank != $past(lo_bank)) |-> $past(lo_vld));

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_vld && !hd_v) |-> !(b0_we || b1_we));

  a_r8_read_bank_moves_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bank != $past(rd_bank)) |-> $past(rd_en));
endmodule

// File: tb/sim_dual_bank_interleaver.sv
module sim_dual_bank_interleaver;
  localparam int DW = 16, LINE_LEN = 64, SKEW = 32, AW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lo_vld = 0, hi_vld = 0, rd_en = 0, rd_hi = 0;
  logic [DW-1:0] lo_data = '0, hi_data = '0, b0_rdata = 16'hA0A0, b1_rdata = 16'hB1B1;
  logic b0_we, b1_we;
  logic [AW-1:0] b0_waddr, b1_waddr, b0_raddr, b1_raddr;
  logic [DW-1:0] b0_wdata, b1_wdata, rd_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_bank_interleaver #(.DW(DW), .LINE_LEN(LINE_LEN), .SKEW(SKEW)) u0 (
    .clk, .rst_n, .lo_vld, .lo_data, .hi_vld, .hi_data, .rd_en, .rd_hi,
    .b0_we, .b0_waddr, .b0_wdata, .b1_we, .b1_waddr, .b1_wdata,
    .b0_raddr, .b1_raddr, .b0_rdata, .b1_rdata, .rd_data);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; lo_vld = 0; hi_vld = 0; rd_en = 0; rd_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic lo_step(input logic [DW-1:0] d);
    @(negedge clk); lo_vld = 1; lo_data = d;
  endtask

  // {lo_vld, lo_data, exp_we0, exp_we1, exp_addr}
  localparam logic [25:0] TBL [6] = '{
    {1'b1, 16'h1111, 1'b1, 1'b0, 7'd0},
    {1'b0, 16'h0000, 1'b0, 1'b0, 7'd0},
    {1'b1, 16'h2222, 1'b1, 1'b0, 7'd1},
    {1'b1, 16'h3333, 1'b1, 1'b0, 7'd2},
    {1'b0, 16'hFFFF, 1'b0, 1'b0, 7'd0},
    {1'b1, 16'h4444, 1'b1, 1'b0, 7'd3}
  };

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R1: reset state
    check(!b0_we && !b1_we, "R1 no write enables", 32'({b0_we, b1_we}), 32'd0);
    check(rd_data == 16'hA0A0, "R1 read from bank 0", 32'(rd_data), 32'hA0A0);
    check(b0_raddr == 7'd0, "R1 read index zero", 32'(b0_raddr), 32'd0);

    // R2 / R9: table walk
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      lo_vld = TBL[i][25]; lo_data = TBL[i][24:9];
      #1;
      check(b0_we == TBL[i][8] && b1_we == TBL[i][7], "R2/R9 enables",
            32'({b0_we, b1_we}), 32'(TBL[i][8:7]));
      if (TBL[i][8]) begin
        check(b0_waddr == TBL[i][6:0], "R2 address", 32'(b0_waddr), 32'(TBL[i][6:0]));
        check(b0_wdata == TBL[i][24:9], "R2 data", 32'(b0_wdata), 32'(TBL[i][24:9]));
      end
    end

    // R3: writes 5..32 stay on bank 0, write 33 moves to bank 1
    for (int i = 5; i <= 32; i++) begin
      lo_step(DW'(i)); #1;
      check(b0_we && !b1_we, "R3 group on bank 0", 32'({b0_we, b1_we}), 32'd2);
    end
    lo_step(16'h0033); #1;
    check(b1_we && !b0_we, "R3 swap to bank 1", 32'({b0_we, b1_we}), 32'd1);
    check(b1_waddr == 7'd32, "R4 index 32", 32'(b1_waddr), 32'd32);
    check(b1_wdata == 16'h0033, "R2 data on bank 1", 32'(b1_wdata), 32'h33);

    // R4: writes 34..64, then write 65 wraps to index 0 on bank 0
    for (int i = 34; i <= 64; i++) lo_step(DW'(i));
    #1;
    check(b1_we && b1_waddr == 7'd63, "R4 last index", 32'(b1_waddr), 32'd63);
    lo_step(16'h0065); #1;
    check(b0_we && !b1_we, "R3 swap back to bank 0", 32'({b0_we, b1_we}), 32'd2);
    check(b0_waddr == 7'd0, "R4 index wrap", 32'(b0_waddr), 32'd0);

    // R5 / R6: high-pass skew
    do_reset();
    @(negedge clk); hi_vld = 1; hi_data = 16'hCAFE; #1;
    check(!b0_we && !b1_we, "R5 no early write", 32'({b0_we, b1_we}), 32'd0);
    for (int i = 1; i < SKEW; i++) begin
      @(negedge clk); hi_vld = 0; #1;
      check(!b0_we && !b1_we, "R5 inside skew window", 32'(i), 32'(SKEW));
    end
    @(negedge clk); lo_vld = 1; lo_data = 16'hBEEF; #1;
    check(b0_we && b1_we, "R6 both writes", 32'({b0_we, b1_we}), 32'd3);
    check(b1_waddr == 7'h40 && b1_wdata == 16'hCAFE, "R5 high-pass to bank 1",
          32'({b1_waddr, b1_wdata}), 32'h40CAFE);
    check(b0_waddr == 7'h00 && b0_wdata == 16'hBEEF, "R6 low-pass to bank 0",
          32'({b0_waddr, b0_wdata}), 32'h00BEEF);
    @(negedge clk); lo_vld = 0; #1;
    check(!b0_we && !b1_we, "R9 idle after", 32'({b0_we, b1_we}), 32'd0);

    // R7 / R8: read side
    do_reset();
    rd_hi = 1;
    #1;
    check(b0_raddr == 7'h40 && b1_raddr == 7'h40, "R7 region bit", 32'(b0_raddr), 32'h40);
    for (int i = 0; i < SKEW; i++) begin
      @(negedge clk); rd_en = 1;
    end
    @(negedge clk); rd_en = 0; #1;
    check(rd_data == 16'hB1B1, "R8 read bank swap", 32'(rd_data), 32'hB1B1);
    check(b1_raddr == 7'h60, "R7 read index 32", 32'(b1_raddr), 32'h60);
    for (int i = 0; i < SKEW; i++) begin
      @(negedge clk); rd_en = 1;
    end
    @(negedge clk); rd_en = 0; rd_hi = 0; #1;
    check(rd_data == 16'hA0A0, "R8 read bank back", 32'(rd_data), 32'hA0A0);
    check(b0_raddr == 7'h00, "R7 read index wrap", 32'(b0_raddr), 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule